// File: doc/BRIEF.md
# Adaptive coherence directory handler

A memory-side request handler that owns the coherence directory of one line. It records which caches hold the line as a write-propagating (WP) copy or as the single migratory copy. Base copies are handed out without being recorded. Cache requests and base writebacks arrive on two independent inputs. The handler answers with one message per cycle: a base copy, a WP copy or an upgrade-to-migratory. Each message is a one-cycle strobe tagged with the destination cache ID.

The handler may also act on its own. A push input hands an unrequested WP copy to a cache. An upgrade enable lets it promote a lone WP holder to migratory. Requests and writebacks can therefore race with messages already in flight. A request from a cache that is already listed is dropped. A writeback from a listed cache removes that cache from the directory. Every base writeback is parked in a four-entry suspended queue, which the memory drains later through a head/pop interface.

Top module: `coh_dir_handler`

## Requirements
- R1: After reset the directory is empty (holders 0, mode 0 = none), no message strobe is raised, the suspended queue is empty and `wb_ready_o` is 1.
- R2: An accepted request from an unlisted cache with `policy_wp_i`=0 raises `cache_b_o` for that cache on the next cycle and leaves the directory unchanged.
- R3: An accepted request from an unlisted cache with `policy_wp_i`=1 raises `cache_w_o` for that cache on the next cycle, sets its holder bit and sets mode 1 (WP). The request itself is then consumed.
- R4: A request from a cache whose holder bit is set is discarded: it produces no message and does not change the directory.
- R5: While mode is 2 (migratory), `req_ready_o` is 0 for a request from any cache other than the migratory holder, and such a request has no effect.
- R6: An accepted writeback from an unlisted cache is appended to the suspended queue, and the directory is unchanged.
- R7: An accepted writeback from a listed cache is appended to the suspended queue and clears that cache's holder bit. When no holder is left, mode returns to 0.
- R8: The suspended queue holds 4 entries and presents them oldest first on `susp_id_o` while `susp_valid_o` is 1. `susp_pop_i` removes the head. `wb_ready_o` is 0 while all 4 entries are occupied.
- R9: With `upg_en_i`=1, mode 1 and exactly one holder, the handler raises `upgrade_o` to that holder and sets mode 2. This happens only if the message slot is free and that holder is not writing back in the same cycle.
- R10: A push to a cache that is unlisted while mode is not 2 sends `cache_w_o` to that cache and adds it as a WP holder. A push to a listed cache, or a push while mode is 2, is ignored.
- R11: At most one message strobe is raised per cycle, and `msg_id_o` names its destination. The priority is request reply, then push, then upgrade. A push or upgrade that loses the slot is dropped.
- R12: A request and a writeback in the same cycle are both judged against the directory as it stood before that cycle. A request and a writeback from the same listed cache therefore discard the request and remove the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| policy_wp_i | input | 1 | 1: answer requests with a WP copy; 0: with a base copy |
| upg_en_i | input | 1 | Allow unsolicited upgrade of a lone WP holder |
| req_valid_i | input | 1 | Cache request present |
| req_id_i | input | ID_W | Requesting cache |
| req_ready_o | output | 1 | Request can be taken this cycle |
| wb_valid_i | input | 1 | Base writeback present |
| wb_id_i | input | ID_W | Writing-back cache |
| wb_ready_o | output | 1 | Suspended queue has room |
| push_valid_i | input | 1 | Unsolicited WP copy wanted |
| push_id_i | input | ID_W | Target of the unsolicited copy |
| susp_valid_o | output | 1 | Suspended queue not empty |
| susp_id_o | output | ID_W | Cache ID of the oldest suspended writeback |
| susp_pop_i | input | 1 | Remove the oldest suspended writeback |
| cache_b_o | output | 1 | Base-copy message strobe |
| cache_w_o | output | 1 | WP-copy message strobe |
| upgrade_o | output | 1 | Upgrade-to-migratory message strobe |
| msg_id_o | output | ID_W | Destination of the current message |
| holders_o | output | NUM_CACHES | Directory holder vector |
| mode_o | output | 2 | Directory mode: 0 none, 1 WP, 2 migratory |

## Verification
Two functions can fall in the same cycle: a writeback that removes a holder, and either a request from that same cache or the upgrade of that holder. The bench provokes the first directly by presenting a request and a writeback from the WP holder on the same edge. It provokes the second by asserting `upg_en_i` while the lone holder writes back. Random stimulus with a high writeback and upgrade rate produces many more such collisions. Each cycle is judged against a bench model that evaluates both inputs against the pre-cycle directory. The model expects the request to be dropped, the upgrade to be withheld, and the holder bit and mode to reflect only the removal.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_WP   = 2'd1,
    MODE_MIG  = 2'd2
  } dir_mode_e;

  typedef enum logic [1:0] {
    MSG_NONE = 2'd0,
    MSG_BASE = 2'd1,
    MSG_WP   = 2'd2,
    MSG_UPG  = 2'd3
  } msg_kind_e;
endpackage

// File: rtl/coh_dir_wbq.sv
module coh_dir_wbq #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned ID_W  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [ID_W-1:0] push_id_i,
  input  logic            pop_i,
  output logic            full_o,
  output logic            valid_o,
  output logic [ID_W-1:0] head_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ID_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign head_o  = mem_q[rd_q];
  assign do_pop  = pop_i && valid_o;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_id_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_i, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r8_push_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !do_pop) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r8_pop_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_pop && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/coh_dir_decide.sv
module coh_dir_decide
  import coh_dir_pkg::*;
#(
  parameter int unsigned NUM_CACHES = 4,
  parameter int unsigned ID_W       = 2
) (
  input  logic [NUM_CACHES-1:0] holders_i,
  input  dir_mode_e             mode_i,
  input  logic                  policy_wp_i,
  input  logic                  upg_en_i,
  input  logic                  req_valid_i,
  input  logic [ID_W-1:0]       req_id_i,
  input  logic                  wb_fire_i,
  input  logic [ID_W-1:0]       wb_id_i,
  input  logic                  push_valid_i,
  input  logic [ID_W-1:0]       push_id_i,
  output logic                  req_ready_o,
  output logic [NUM_CACHES-1:0] holders_nxt_o,
  output dir_mode_e             mode_nxt_o,
  output msg_kind_e             kind_nxt_o,
  output logic [ID_W-1:0]       id_nxt_o
);
  logic                  req_hit, push_hit, req_ok, upgrade;
  logic [NUM_CACHES-1:0] rm_vec, add_vec;
  logic [ID_W:0]         holder_cnt;
  logic [ID_W-1:0]       solo_id;

  always_comb begin
    holder_cnt = '0;
    solo_id    = '0;
    for (int i = 0; i < NUM_CACHES; i++) begin
      if (holders_i[i]) begin
        holder_cnt = holder_cnt + 1'b1;
        solo_id    = ID_W'(i);
      end
    end
  end

  always_comb begin
    req_hit  = holders_i[req_id_i];
    push_hit = holders_i[push_id_i];
    req_ok   = !(mode_i == MODE_MIG && !req_hit);
    rm_vec   = '0;
    add_vec  = '0;
    upgrade  = 1'b0;
    kind_nxt_o = MSG_NONE;
    id_nxt_o   = '0;
    // writebacks see the pre-cycle directory, as do requests
    if (wb_fire_i && holders_i[wb_id_i]) rm_vec[wb_id_i] = 1'b1;
    if (req_valid_i && req_ok && !req_hit) begin
      id_nxt_o = req_id_i;
      if (policy_wp_i) begin
        kind_nxt_o        = MSG_WP;
        add_vec[req_id_i] = 1'b1;
      end else begin
        kind_nxt_o = MSG_BASE;
      end
    end else if (push_valid_i && !push_hit && mode_i != MODE_MIG) begin
      kind_nxt_o         = MSG_WP;
      id_nxt_o           = push_id_i;
      add_vec[push_id_i] = 1'b1;
    end else if (upg_en_i && mode_i == MODE_WP && holder_cnt == 1 && !rm_vec[solo_id]) begin
      kind_nxt_o = MSG_UPG;
      id_nxt_o   = solo_id;
      upgrade    = 1'b1;
    end
    holders_nxt_o = (holders_i & ~rm_vec) | add_vec;
    if (upgrade)                  mode_nxt_o = MODE_MIG;
    else if (holders_nxt_o == '0) mode_nxt_o = MODE_NONE;
    else if (mode_i == MODE_MIG)  mode_nxt_o = MODE_MIG;
    else                          mode_nxt_o = MODE_WP;
    req_ready_o = req_ok;
  end
endmodule

// File: rtl/coh_dir_state.sv
module coh_dir_state
  import coh_dir_pkg::*;
#(
  parameter int unsigned NUM_CACHES = 4,
  parameter int unsigned ID_W       = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_CACHES-1:0] holders_nxt_i,
  input  dir_mode_e             mode_nxt_i,
  input  msg_kind_e             kind_nxt_i,
  input  logic [ID_W-1:0]       id_nxt_i,
  output logic [NUM_CACHES-1:0] holders_o,
  output dir_mode_e             mode_o,
  output logic                  cache_b_o,
  output logic                  cache_w_o,
  output logic                  upgrade_o,
  output logic [ID_W-1:0]       msg_id_o
);
  logic [NUM_CACHES-1:0] holders_q;
  dir_mode_e             mode_q;
  msg_kind_e             kind_q;
  logic [ID_W-1:0]       id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      holders_q <= '0;
      mode_q    <= MODE_NONE;
      kind_q    <= MSG_NONE;
      id_q      <= '0;
    end else begin
      holders_q <= holders_nxt_i;
      mode_q    <= mode_nxt_i;
      kind_q    <= kind_nxt_i;
      id_q      <= id_nxt_i;
    end
  end

  assign holders_o = holders_q;
  assign mode_o    = mode_q;
  assign cache_b_o = (kind_q == MSG_BASE);
  assign cache_w_o = (kind_q == MSG_WP);
  assign upgrade_o = (kind_q == MSG_UPG);
  assign msg_id_o  = id_q;

  a_r11_one_msg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cache_b_o, cache_w_o, upgrade_o}));
  a_r5_mig_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_MIG) |-> ($countones(holders_q) == 1));
  a_r3_wp_listed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_w_o |-> holders_q[msg_id_o]);
  a_r2_base_unlisted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_b_o |-> !holders_q[msg_id_o]);
  a_r9_upgrade_from_wp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upgrade_o |-> ($past(mode_q) == MODE_WP && mode_q == MODE_MIG));
  a_r7_empty_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (holders_q == '0) |-> (mode_q == MODE_NONE));
endmodule

// File: rtl/coh_dir_handler.sv
module coh_dir_handler
  import coh_dir_pkg::*;
#(
  parameter int unsigned NUM_CACHES = 4,
  parameter int unsigned WBQ_DEPTH  = 4,
  parameter int unsigned ID_W       = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  policy_wp_i,
  input  logic                  upg_en_i,
  input  logic                  req_valid_i,
  input  logic [ID_W-1:0]       req_id_i,
  output logic                  req_ready_o,
  input  logic                  wb_valid_i,
  input  logic [ID_W-1:0]       wb_id_i,
  output logic                  wb_ready_o,
  input  logic                  push_valid_i,
  input  logic [ID_W-1:0]       push_id_i,
  output logic                  susp_valid_o,
  output logic [ID_W-1:0]       susp_id_o,
  input  logic                  susp_pop_i,
  output logic                  cache_b_o,
  output logic                  cache_w_o,
  output logic                  upgrade_o,
  output logic [ID_W-1:0]       msg_id_o,
  output logic [NUM_CACHES-1:0] holders_o,
  output logic [1:0]            mode_o
);
  logic                  q_full, wb_fire;
  logic [NUM_CACHES-1:0] holders, holders_nxt;
  dir_mode_e             mode, mode_nxt;
  msg_kind_e             kind_nxt;
  logic [ID_W-1:0]       id_nxt;

  assign wb_ready_o = !q_full;
  assign wb_fire    = wb_valid_i && !q_full;
  assign holders_o  = holders;
  assign mode_o     = mode;

  coh_dir_wbq #(.DEPTH(WBQ_DEPTH), .ID_W(ID_W)) u_wbq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (wb_fire),
    .push_id_i (wb_id_i),
    .pop_i     (susp_pop_i),
    .full_o    (q_full),
    .valid_o   (susp_valid_o),
    .head_o    (susp_id_o)
  );

  coh_dir_decide #(.NUM_CACHES(NUM_CACHES), .ID_W(ID_W)) u_decide (
    .holders_i     (holders),
    .mode_i        (mode),
    .policy_wp_i   (policy_wp_i),
    .upg_en_i      (upg_en_i),
    .req_valid_i   (req_valid_i),
    .req_id_i      (req_id_i),
    .wb_fire_i     (wb_fire),
    .wb_id_i       (wb_id_i),
    .push_valid_i  (push_valid_i),
    .push_id_i     (push_id_i),
    .req_ready_o   (req_ready_o),
    .holders_nxt_o (holders_nxt),
    .mode_nxt_o    (mode_nxt),
    .kind_nxt_o    (kind_nxt),
    .id_nxt_o      (id_nxt)
  );

  coh_dir_state #(.NUM_CACHES(NUM_CACHES), .ID_W(ID_W)) u_state (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .holders_nxt_i (holders_nxt),
    .mode_nxt_i    (mode_nxt),
    .kind_nxt_i    (kind_nxt),
    .id_nxt_i      (id_nxt),
    .holders_o     (holders),
    .mode_o        (mode),
    .cache_b_o     (cache_b_o),
    .cache_w_o     (cache_w_o),
    .upgrade_o     (upgrade_o),
    .msg_id_o      (msg_id_o)
  );

  a_r4_listed_no_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && holders[req_id_i] && !push_valid_i && !upg_en_i) |=> !(cache_b_o || cache_w_o));
  a_r8_ready_when_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!susp_valid_o) |-> wb_ready_o);
endmodule

// File: tb/coh_dir_handler_tb.sv
`timescale 1ns/1ps
module coh_dir_handler_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       policy_wp_i = 0, upg_en_i = 0, req_valid_i = 0, wb_valid_i = 0;
  logic       push_valid_i = 0, susp_pop_i = 0;
  logic [1:0] req_id_i = 0, wb_id_i = 0, push_id_i = 0;
  logic       req_ready_o, wb_ready_o, susp_valid_o, cache_b_o, cache_w_o, upgrade_o;
  logic [1:0] susp_id_o, msg_id_o, mode_o;
  logic [3:0] holders_o;

  int checks = 0, failures = 0;
  logic [3:0] m_hold = 0;
  logic [1:0] m_mode = 0;
  logic [1:0] mq[$];

  always #2.5 clk_i = ~clk_i;

  coh_dir_handler u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check comb outputs, then registered ones
  task automatic step(input bit rv, input logic [1:0] rid, input bit wv, input logic [1:0] wid,
                      input bit pv, input logic [1:0] pid, input bit ue, input bit pol, input bit pop);
    bit rdy, wfire;
    logic [3:0] rm, add, hn;
    logic [1:0] ek, eid, solo, mn;
    int cnt;
    req_valid_i = rv; req_id_i = rid; wb_valid_i = wv; wb_id_i = wid;
    push_valid_i = pv; push_id_i = pid; upg_en_i = ue; policy_wp_i = pol; susp_pop_i = pop;
    #1;
    rdy = !(m_mode == 2 && !m_hold[rid]);
    chk("R5 req_ready", req_ready_o, rdy);
    chk("R8 wb_ready", wb_ready_o, mq.size() < 4);
    chk("R8 susp_valid", susp_valid_o, mq.size() > 0);
    if (mq.size() > 0) chk("R8 susp_id", susp_id_o, mq[0]);
    wfire = wv && (mq.size() < 4);
    rm = 0; add = 0; ek = 0; eid = 0; cnt = 0; solo = 0;
    for (int i = 0; i < 4; i++) if (m_hold[i]) begin cnt++; solo = 2'(i); end
    if (wfire && m_hold[wid]) rm[wid] = 1;
    if (rv && rdy && !m_hold[rid]) begin
      eid = rid;
      if (pol) begin ek = 2; add[rid] = 1; end else ek = 1;
    end else if (pv && !m_hold[pid] && m_mode != 2) begin
      ek = 2; eid = pid; add[pid] = 1;
    end else if (ue && m_mode == 1 && cnt == 1 && !rm[solo]) begin
      ek = 3; eid = solo;
    end
    hn = (m_hold & ~rm) | add;
    if (ek == 3) mn = 2;
    else if (hn == 0) mn = 0;
    else if (m_mode == 2) mn = 2;
    else mn = 1;
    @(posedge clk_i);
    @(negedge clk_i);
    if (pop && mq.size() > 0) void'(mq.pop_front());
    if (wfire) mq.push_back(wid);
    m_hold = hn; m_mode = mn;
    chk("R7 holders", holders_o, m_hold);
    chk("R9 mode", mode_o, m_mode);
    chk("R2 cache_b", cache_b_o, ek == 1);
    chk("R3 cache_w", cache_w_o, ek == 2);
    chk("R9 upgrade", upgrade_o, ek == 3);
    if (ek != 0) chk("R11 msg_id", msg_id_o, eid);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 holders", holders_o, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 msgs", {cache_b_o, cache_w_o, upgrade_o}, 0);
    chk("R1 wb_ready", wb_ready_o, 1);
    chk("R1 susp_valid", susp_valid_o, 0);
    @(negedge clk_i);

    step(1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 base to 1", {cache_b_o, msg_id_o, holders_o}, {1'b1, 2'd1, 4'b0000});
    step(1, 2, 0, 0, 0, 0, 0, 1, 0);
    chk("R3 wp to 2", {cache_w_o, msg_id_o, holders_o, mode_o}, {1'b1, 2'd2, 4'b0100, 2'd1});
    step(1, 2, 0, 0, 0, 0, 0, 1, 0);
    chk("R4 listed discarded", {cache_b_o, cache_w_o, holders_o}, {2'b00, 4'b0100});
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R9 upgrade 2", {upgrade_o, msg_id_o, mode_o}, {1'b1, 2'd2, 2'd2});
    req_valid_i = 1; req_id_i = 0; #1;
    chk("R5 blocked by mig", req_ready_o, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 no effect", {cache_b_o, cache_w_o, holders_o}, {2'b00, 4'b0100});
    step(0, 0, 0, 0, 1, 1, 0, 0, 0);
    chk("R10 push ignored under mig", {cache_w_o, holders_o}, {1'b0, 4'b0100});
    step(1, 2, 0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // reach WP with lone holder 2 again: drop to none then add
    step(0, 0, 1, 2, 0, 0, 0, 0, 0);
    step(1, 2, 0, 0, 0, 0, 0, 1, 0);
    step(1, 2, 1, 2, 0, 0, 1, 1, 0);
    chk("R12 same-cycle req+wb", {cache_w_o, upgrade_o, holders_o, mode_o}, {2'b00, 4'b0000, 2'd0});
    step(0, 0, 1, 3, 0, 0, 0, 0, 0);
    chk("R6 unlisted wb queued", {holders_o, susp_valid_o}, {4'b0000, 1'b1});
    step(0, 0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 0, 0, 0, 0, 0);
    #1; chk("R8 full", wb_ready_o, 0);
    step(0, 0, 1, 2, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    #1; chk("R8 drained", susp_valid_o, 0);
    step(0, 0, 0, 0, 1, 3, 0, 0, 0);
    chk("R10 push adds 3", {cache_w_o, msg_id_o, holders_o}, {1'b1, 2'd3, 4'b1000});
    step(1, 0, 0, 0, 1, 1, 0, 0, 0);
    chk("R11 req beats push", {cache_b_o, cache_w_o, msg_id_o, holders_o}, {2'b10, 2'd0, 4'b1000});
    step(0, 0, 1, 3, 0, 0, 0, 0, 0);
    chk("R7 last holder gone", {holders_o, mode_o}, {4'b0000, 2'd0});

    for (int n = 0; n < 3000; n++)
      step(($urandom % 10) < 4, 2'($urandom), ($urandom % 10) < 3, 2'($urandom),
           ($urandom % 10) < 2, 2'($urandom), ($urandom % 10) < 3, ($urandom % 2) == 1,
           ($urandom % 10) < 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule